// File: doc/BRIEF.md
# Bus Cycle Status Decoder

This block sits beside an 8-bit microprocessor that has no dedicated cycle-type pins. At the start of every machine cycle the processor places a status byte on its shared data bus and raises a sync strobe. The block keeps that byte in a register. For the rest of the cycle it combines the stored byte with the data-in strobe (`dbin`) and the active-low write strobe (`wr_n`). From these it produces separate strobes for instruction fetch, memory read, memory write, port read and port write.

For port cycles the processor drives the 8-bit port number on both halves of the 16-bit address bus. The block outputs the low half as the port number. A port strobe is issued only when the two halves agree. When they disagree, the strobe is withheld and a sticky error flag is raised. Memory arrays and peripherals connect straight to the strobes. Write targets capture data on the falling edge of the write strobe they receive, which is the rising edge of `wr_n`.

Top module: `bus_status_decoder`

## Requirements
- R1: While reset is applied, and after reset until the first sync capture, every strobe and `proto_err` is low, whatever `dbin` and `wr_n` do.
- R2: On each rising clock edge with `sync` high, the data bus is stored as the status byte. With `sync` low, the stored byte holds and data bus changes have no effect. The last byte taken in a multi-cycle sync window governs.
- R3: Stored byte 0x20 (only bit 5 set) is a fetch cycle. `fetch` and `mem_rd` both follow `dbin`.
- R4: Stored byte 0x80 (only bit 7 set) is a memory read. `mem_rd` follows `dbin` and `fetch` stays low.
- R5: Stored byte 0x02 (only bit 1 set) is a memory write. `mem_wr` is high while `wr_n` is low.
- R6: Stored byte 0x40 (only bit 6 set) is a port read. `io_rd` follows `dbin` while `addr[7:0]` equals `addr[15:8]`.
- R7: Stored byte 0x12 (bits 4 and 1 set) is a port write. `io_wr` is high while `wr_n` is low and the two address halves are equal.
- R8: `io_port` equals `addr[7:0]` during port read and port write cycles, and is 0 in all other cycles.
- R9: In a port cycle where the direction strobe is active and the address halves differ, the port strobe stays low and `proto_err` goes high from the next rising edge. It stays high until a rising edge with `sync` high clears it.
- R10: Any other stored byte decodes to no cycle, and every strobe stays low.
- R11: While `sync` is high, every strobe is low.
- R12: A read cycle ignores `wr_n` and a write cycle ignores `dbin`. The strobe of the other direction never fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 16 | Processor address bus |
| data | input | 8 | Processor data bus; carries the status byte while sync is high |
| sync | input | 1 | Status-valid strobe |
| dbin | input | 1 | Data-in strobe, high while the processor reads |
| wr_n | input | 1 | Active-low write strobe |
| fetch | output | 1 | Instruction fetch read strobe |
| mem_rd | output | 1 | Memory read strobe (also during fetch) |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | Port read strobe |
| io_wr | output | 1 | Port write strobe |
| io_port | output | 8 | Port number during port cycles, else 0 |
| proto_err | output | 1 | Sticky flag for mismatched port address halves |

## Verification
The bench builds the block with its default values: a 16-bit address bus, which gives an 8-bit port number, and a two-stage reset synchronizer. With these values the random address draw has the two halves equal in about half the draws, so both the accepted and the refused paths of every port cycle are exercised, across the full range of port numbers. Status bytes come from the five valid codes, from corrupted codes and from arbitrary bytes, so the no-cycle decode is exercised alongside every legal cycle type.

// File: rtl/bus_status_pkg.sv
package bus_status_pkg;
  localparam int STATUS_W = 8;

  typedef enum logic [2:0] {
    CYC_NONE,
    CYC_FETCH,
    CYC_MRD,
    CYC_MWR,
    CYC_IORD,
    CYC_IOWR
  } cyc_e;

  localparam logic [STATUS_W-1:0] CODE_FETCH = 8'h20;
  localparam logic [STATUS_W-1:0] CODE_MRD   = 8'h80;
  localparam logic [STATUS_W-1:0] CODE_MWR   = 8'h02;
  localparam logic [STATUS_W-1:0] CODE_IORD  = 8'h40;
  localparam logic [STATUS_W-1:0] CODE_IOWR  = 8'h12;
endpackage

// File: rtl/bus_rst_sync.sv
module bus_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n = chain_q[STAGES-1];
endmodule

// File: rtl/bus_status_latch.sv
module bus_status_latch
  import bus_status_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sync,
  input  logic [STATUS_W-1:0] data,
  output logic [STATUS_W-1:0] status_q
);
  logic                status_en;
  logic [STATUS_W-1:0] status_d;

  assign status_en = sync;

  always_comb begin
    status_d = status_q;
    if (status_en) status_d = data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  // R2: capture during sync, hold otherwise
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> status_q == $past(data));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sync |=> $stable(status_q));
endmodule

// File: rtl/bus_cycle_decode.sv
module bus_cycle_decode
  import bus_status_pkg::*;
(
  input  logic [STATUS_W-1:0] status,
  output cyc_e                cyc
);
  always_comb begin
    unique case (status)
      CODE_FETCH: cyc = CYC_FETCH;
      CODE_MRD:   cyc = CYC_MRD;
      CODE_MWR:   cyc = CYC_MWR;
      CODE_IORD:  cyc = CYC_IORD;
      CODE_IOWR:  cyc = CYC_IOWR;
      default:    cyc = CYC_NONE;
    endcase
  end
endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
  import bus_status_pkg::*;
#(
  parameter int ADDR_W = 16,
  localparam int PORT_W = ADDR_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cyc_e              cyc,
  input  logic              sync,
  input  logic              dbin,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              fetch,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              io_rd,
  output logic              io_wr,
  output logic [PORT_W-1:0] io_port,
  output logic              proto_err
);
  logic [PORT_W-1:0] lane_eq;
  logic              halves_match;
  logic              rd_ok, wr_ok, io_cyc, io_req, err_d, err_q;

  for (genvar i = 0; i < PORT_W; i++) begin : g_lane
    assign lane_eq[i] = ~(addr[i] ^ addr[PORT_W + i]);
  end
  assign halves_match = &lane_eq;

  assign rd_ok  = dbin & ~sync;
  assign wr_ok  = ~wr_n & ~sync;
  assign io_cyc = (cyc == CYC_IORD) | (cyc == CYC_IOWR);
  assign io_req = (rd_ok & (cyc == CYC_IORD)) | (wr_ok & (cyc == CYC_IOWR));

  always_comb begin
    fetch   = rd_ok & (cyc == CYC_FETCH);
    mem_rd  = rd_ok & ((cyc == CYC_FETCH) | (cyc == CYC_MRD));
    mem_wr  = wr_ok & (cyc == CYC_MWR);
    io_rd   = rd_ok & (cyc == CYC_IORD) & halves_match;
    io_wr   = wr_ok & (cyc == CYC_IOWR) & halves_match;
    io_port = io_cyc ? addr[PORT_W-1:0] : '0;
  end

  always_comb begin
    err_d = err_q;
    if (sync)                         err_d = 1'b0;
    else if (io_req && !halves_match) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end
  assign proto_err = err_q;

  // R12: strobes only with their own direction strobe
  a_r12_read_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || io_rd) |-> dbin);
  a_r12_write_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr || io_wr) |-> !wr_n);
  // R11: quiet during status window
  a_r11_sync_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    sync |-> !(fetch || mem_rd || mem_wr || io_rd || io_wr));
  // R3: fetch is a memory read
  a_r3_fetch_reads: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |-> mem_rd);
  // R6/R7: at most one bus strobe kind at once
  a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr, io_rd, io_wr}));
  // R9: port strobes need matching halves; flag sticky until sync
  a_r9_match: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd || io_wr) |-> addr[PORT_W-1:0] == addr[ADDR_W-1:PORT_W]);
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (proto_err && !sync) |=> proto_err);
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> !proto_err);
endmodule

// File: rtl/bus_status_decoder.sv
module bus_status_decoder
  import bus_status_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int RST_STAGES = 2,
  localparam int PORT_W    = ADDR_W / 2
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  input  logic              sync,
  input  logic              dbin,
  input  logic              wr_n,
  output logic              fetch,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              io_rd,
  output logic              io_wr,
  output logic [PORT_W-1:0] io_port,
  output logic              proto_err
);
  logic                rst_n;
  logic [STATUS_W-1:0] status_q;
  cyc_e                cyc;

  bus_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .arst_n(arst_n), .rst_n(rst_n)
  );

  bus_status_latch u_latch (
    .clk(clk), .rst_n(rst_n), .sync(sync), .data(data), .status_q(status_q)
  );

  bus_cycle_decode u_dec (.status(status_q), .cyc(cyc));

  bus_strobe_gen #(.ADDR_W(ADDR_W)) u_strb (
    .clk(clk), .rst_n(rst_n), .cyc(cyc), .sync(sync), .dbin(dbin),
    .wr_n(wr_n), .addr(addr), .fetch(fetch), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr), .io_port(io_port),
    .proto_err(proto_err)
  );

  // R1: nothing fires while reset holds
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> !(fetch || mem_rd || mem_wr || io_rd || io_wr || proto_err));
endmodule

// File: tb/tb_bus_status_decoder.sv
module tb_bus_status_decoder;
  logic        clk = 1'b0;
  logic        arst_n;
  logic [15:0] addr;
  logic [7:0]  data;
  logic        sync, dbin, wr_n;
  logic        fetch, mem_rd, mem_wr, io_rd, io_wr, proto_err;
  logic [7:0]  io_port;
  int          checks = 0;
  int          errors = 0;
  logic [7:0]  exp_st;
  logic        exp_err;

  always #10 clk = ~clk;

  bus_status_decoder dut (
    .clk(clk), .arst_n(arst_n), .addr(addr), .data(data), .sync(sync),
    .dbin(dbin), .wr_n(wr_n), .fetch(fetch), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr), .io_port(io_port),
    .proto_err(proto_err)
  );

  function automatic logic [12:0] model(input logic [7:0] st, input logic [15:0] a,
                                        input logic s, input logic rd, input logic wn);
    logic rdo, wro, m, f, mr, mw, ir, iw;
    logic [7:0] p;
    rdo = rd & ~s;
    wro = ~wn & ~s;
    m   = (a[7:0] == a[15:8]);
    f   = rdo & (st == 8'h20);
    mr  = rdo & ((st == 8'h20) | (st == 8'h80));
    mw  = wro & (st == 8'h02);
    ir  = rdo & (st == 8'h40) & m;
    iw  = wro & (st == 8'h12) & m;
    p   = ((st == 8'h40) || (st == 8'h12)) ? a[7:0] : 8'h00;
    return {f, mr, mw, ir, iw, p};
  endfunction

  function automatic logic err_next(input logic e, input logic [7:0] st, input logic [15:0] a,
                                    input logic s, input logic rd, input logic wn);
    if (s) return 1'b0;
    if (((rd && st == 8'h40) || (!wn && st == 8'h12)) && a[7:0] != a[15:8]) return 1'b1;
    return e;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_strobes(input string req);
    check(req, {3'b0, fetch, mem_rd, mem_wr, io_rd, io_wr, io_port},
          {3'b0, model(exp_st, addr, sync, dbin, wr_n)});
  endtask

  task automatic latch_byte(input logic [7:0] b);
    @(negedge clk);
    sync = 1'b1; data = b; dbin = 1'b0; wr_n = 1'b1;
    @(negedge clk);
    sync = 1'b0; exp_st = b; exp_err = 1'b0;
  endtask

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    arst_n = 1'b0; addr = 16'h3434; data = 8'h40; sync = 1'b0; dbin = 1'b1; wr_n = 1'b0;
    exp_st = 8'h00; exp_err = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 in reset", {10'b0, fetch, mem_rd, mem_wr, io_rd, io_wr, proto_err}, 16'h0);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after reset", {10'b0, fetch, mem_rd, mem_wr, io_rd, io_wr, proto_err}, 16'h0);
    dbin = 1'b0; wr_n = 1'b1;

    // R2: held while sync low, data bus wiggling
    latch_byte(8'h40);
    addr = 16'h5A5A; dbin = 1'b1;
    for (int k = 0; k < 3; k++) begin
      data = 8'h80 ^ k[7:0];
      @(negedge clk); #2;
      check("R2 hold R6", {15'b0, io_rd}, 16'h1);
      check("R2 hold R8", {8'b0, io_port}, 16'h005A);
    end
    // R11: sync high silences strobes
    sync = 1'b1; data = 8'h40; #2;
    check("R11 sync quiet", {11'b0, fetch, mem_rd, mem_wr, io_rd, io_wr}, 16'h0);
    // R2: last byte of a two-cycle sync window wins
    @(negedge clk); data = 8'h02; dbin = 1'b0;
    @(negedge clk); sync = 1'b0; exp_st = 8'h02; wr_n = 1'b0; #2;
    check("R2 last byte R5", {15'b0, mem_wr}, 16'h1);
    dbin = 1'b1; #2;
    check("R12 write ignores dbin", {11'b0, fetch, mem_rd, mem_wr, io_rd, io_wr}, 16'h0004);
    wr_n = 1'b1;

    // R9 directed: mismatch, then recovery, then clear
    latch_byte(8'h12);
    addr = 16'h1234; wr_n = 1'b0; #2;
    check("R9 suppressed", {15'b0, io_wr}, 16'h0);
    @(negedge clk);
    check("R9 flag set", {15'b0, proto_err}, 16'h1);
    addr = 16'h3434; #2;
    check("R7 match", {15'b0, io_wr}, 16'h1);
    @(negedge clk);
    check("R9 sticky", {15'b0, proto_err}, 16'h1);
    wr_n = 1'b1;
    latch_byte(8'h80);
    check("R9 clear", {15'b0, proto_err}, 16'h0);

    // random mix
    for (int it = 0; it < 600; it++) begin
      logic [7:0] st;
      logic [7:0] lo;
      int pick;
      logic en;
      pick = $urandom_range(0, 6);
      case (pick)
        0: st = 8'h20;
        1: st = 8'h80;
        2: st = 8'h02;
        3: st = 8'h40;
        4: st = 8'h12;
        5: st = 8'($urandom);
        default: st = 8'h40 ^ (8'h01 << $urandom_range(0, 5));
      endcase
      @(negedge clk);
      sync = 1'b1; data = st; dbin = 1'($urandom); wr_n = 1'($urandom);
      #2 check_strobes("R11 random sync window");
      @(negedge clk);
      exp_st = st;
      exp_err = 1'b0;
      check("R9 clear on sync", {15'b0, proto_err}, 16'h0);
      sync = 1'b0; data = 8'($urandom);
      lo = 8'($urandom);
      addr = {($urandom_range(0, 1) == 1) ? lo : 8'($urandom), lo};
      dbin = 1'($urandom); wr_n = 1'($urandom);
      #2 check_strobes("R3 R4 R5 R6 R7 R8 R10 R12 random cycle");
      en = err_next(exp_err, exp_st, addr, sync, dbin, wr_n);
      @(negedge clk);
      exp_err = en;
      check("R9 random flag", {15'b0, proto_err}, {15'b0, exp_err});
      dbin = 1'b0; wr_n = 1'b1;
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule